// File: doc/BRIEF.md
# Programmable interval timer channel

This block is a single 16-bit binary timer channel. A host-side register block, kept elsewhere, hands it a reload value and a 3-bit mode together with a one-cycle load strobe. From then on the channel advances only on cycles where the count-enable strobe is high. It drives one output line whose waveform depends on the mode: a terminal-count level, a retriggerable one-shot, a rate generator, a square wave, or a single strobe pulse. It also exposes a live 16-bit count that the register block can read back.

A gate input either pauses counting or restarts it on a rising edge, depending on the mode. The gate is sampled into a register, so a rising edge is a cycle where the gate is high and its registered copy is low. Counting is always binary; a reload value of zero stands for a full 65536-step period.

Top module: `pit_channel`

## Requirements
- R1: After a synchronous reset the channel holds mode 0 with a reload value of 0, the output is low and the readback count is 0.
- R2: A reload value of 0 behaves as a period of 65536 count-enable steps in every mode.
- R3: Mode 0: after a load, `out_o` is low. It rises once the elapsed step count d reaches the period N and stays high until the next load. Readback is (N - d) mod 65536.
- R4: Mode 1: `out_o` is low while d < N and high from d = N on. Readback is (N - d) mod 65536.
- R5: Mode 2: `out_o` is low exactly when d mod N = 0 and d is not 0, and high otherwise. Readback is (N - (d mod N)) mod 65536.
- R6: Mode 3: `out_o` is high while (d mod N) < (N+1)/2 (integer division) and low otherwise. Readback is (N - (2d mod N)) mod 65536, so it falls by two per step.
- R7: Modes 4 and 5: `out_o` is high only while d = N, which gives one pulse lasting a single step.
- R8: In modes 1, 2, 3 and 5, a rising gate edge that is not accompanied by a load sets d back to 0.
- R9: In modes 0 and 4, a low gate stops d from advancing and a rising edge does not restart it. While the gate is low, readback and `out_o` stay unchanged.
- R10: A load strobe sets d to 0 and captures the reload value and the mode. A load takes priority over a gate restart and over a count-enable step in the same cycle. The mode input is ignored on other cycles.
- R11: Mode codes 6 and 7 behave exactly as modes 2 and 3.
- R12: d advances by one only on cycles where `tick_i` is high. On other cycles the readback and `out_o` do not change unless a load or a restart occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | One-cycle strobe that captures reload and mode and restarts the sequence |
| reload_i | input | 16 | Reload value; 0 means 65536 |
| mode_i | input | 3 | Counting mode, sampled with the load strobe |
| gate_i | input | 1 | Gate level |
| tick_i | input | 1 | Count-enable strobe |
| out_o | output | 1 | Timer output line |
| count_o | output | 16 | Live count for readback |

## Verification
Every state register reaches the ports within a single cycle. A wrong elapsed count or a wrong phase therefore shows up at the next sample, either as a readback value that differs from the period minus d, or as an edge on `out_o` one step early or late. A stale captured mode, or a missed gate edge, first appears at the next tick. A wrong terminal value, such as treating 0 as 0 rather than 65536, only shows once a full period has elapsed, so that case is run to completion.

// File: rtl/pit_pkg.sv
// Shared types and helpers for the interval timer channel.
// Assumes binary counting only; mode codes 6 and 7 fold onto 2 and 3.
package pit_pkg;

    typedef enum logic [2:0] {
        MODE_TERM    = 3'd0,
        MODE_ONESHOT = 3'd1,
        MODE_RATE    = 3'd2,
        MODE_SQUARE  = 3'd3,
        MODE_SWSTB   = 3'd4,
        MODE_HWSTB   = 3'd5
    } pit_mode_e;

    // Map a raw 3-bit mode code onto the six distinct behaviours.
    function automatic pit_mode_e fold_mode(input logic [2:0] raw);
        case (raw)
            3'd6:    fold_mode = MODE_RATE;
            3'd7:    fold_mode = MODE_SQUARE;
            default: fold_mode = pit_mode_e'(raw);
        endcase
    endfunction

    // True for modes whose gate acts as a level enable rather than a trigger.
    function automatic logic gate_is_level(input pit_mode_e m);
        gate_is_level = (m == MODE_TERM) || (m == MODE_SWSTB);
    endfunction

endpackage

// File: rtl/pit_cfg_reg.sv
// Captures reload value and mode on the load strobe.
// Provides both the registered period and the period that holds after this edge,
// so the counting core can initialise itself from a value loaded in the same cycle.
// Assumes a reload value of zero stands for 2**CW.
module pit_cfg_reg
    import pit_pkg::*;
#(
    parameter int CW = 16,
    localparam int NW = CW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] reload_i,
    input  logic [2:0]    mode_i,
    output logic [NW-1:0] period_q_o,
    output logic [NW-1:0] period_nx_o,
    output pit_mode_e     mode_q_o
);

    logic [NW-1:0] period_q;
    logic [NW-1:0] reload_wide;
    pit_mode_e     mode_q;

    // Widen the reload value, turning zero into the full period.
    always_comb begin
        if (reload_i == '0) reload_wide = {1'b1, {CW{1'b0}}};
        else                reload_wide = {1'b0, reload_i};
    end

    // Period in force after the current edge.
    always_comb begin
        period_nx_o = load_i ? reload_wide : period_q;
    end

    // Configuration registers, reset to mode 0 with a full period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= {1'b1, {CW{1'b0}}};
            mode_q   <= MODE_TERM;
        end else if (load_i) begin
            period_q <= reload_wide;
            mode_q   <= fold_mode(mode_i);
        end
    end

    assign period_q_o = period_q;
    assign mode_q_o   = mode_q;

    // Captured period is never zero after folding.
    AST_PERIOD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        period_q != '0);  // R2

endmodule

// File: rtl/pit_gate_ctl.sv
// Gate handling: registers the gate, detects rising edges and decides
// whether this cycle steps the count or restarts it.
// Assumes the mode input is the captured mode, not the raw host value.
module pit_gate_ctl
    import pit_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      gate_i,
    input  logic      tick_i,
    input  pit_mode_e mode_i,
    output logic      run_o,
    output logic      restart_o
);

    logic gate_q;
    logic gate_rise;

    // Registered gate copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate_i;
    end

    // Edge, restart and step decisions.
    always_comb begin
        gate_rise = gate_i & ~gate_q;
        restart_o = gate_rise & ~gate_is_level(mode_i);
        run_o     = tick_i & (gate_i | ~gate_is_level(mode_i));
    end

    // Level-gated modes never step with the gate low.
    AST_LEVEL_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_is_level(mode_i) && !gate_i) |-> !run_o);  // R9

endmodule

// File: rtl/pit_count_core.sv
// Counting core. It keeps the elapsed step count (saturating just past the
// period), the phase within the period, the doubled phase used by the square
// wave, a wrapping down-counter for the one-shot readback and a started flag.
// Assumes clear_i and step_i are never high together.
module pit_count_core #(
    parameter int CW = 16,
    localparam int NW = CW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          step_i,
    input  logic [NW-1:0] period_i,
    output logic [NW-1:0] elapsed_o,
    output logic [NW-1:0] phase_o,
    output logic [NW-1:0] phase2_o,
    output logic [CW-1:0] down_o,
    output logic          begun_o
);

    logic [NW-1:0] el_q, ph_q, ph2_q;
    logic [CW-1:0] down_q;
    logic          begun_q;

    logic [NW-1:0] el_nx, ph_inc, ph_nx, ph2_a, ph2_b, ph2_nx;

    // Next values for one step.
    always_comb begin
        el_nx  = (el_q > period_i) ? el_q : el_q + 1'b1;
        ph_inc = ph_q + 1'b1;
        ph_nx  = (ph_inc == period_i) ? '0 : ph_inc;
        ph2_a  = ph2_q + NW'(2);
        ph2_b  = (ph2_a >= period_i) ? ph2_a - period_i : ph2_a;
        ph2_nx = (ph2_b >= period_i) ? ph2_b - period_i : ph2_b;
    end

    // State update: clear on load or restart, advance on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            el_q    <= '0;
            ph_q    <= '0;
            ph2_q   <= '0;
            down_q  <= '0;
            begun_q <= 1'b0;
        end else if (clear_i) begin
            el_q    <= '0;
            ph_q    <= '0;
            ph2_q   <= '0;
            down_q  <= period_i[CW-1:0];
            begun_q <= 1'b0;
        end else if (step_i) begin
            el_q    <= el_nx;
            ph_q    <= ph_nx;
            ph2_q   <= ph2_nx;
            down_q  <= down_q - 1'b1;
            begun_q <= 1'b1;
        end
    end

    assign elapsed_o = el_q;
    assign phase_o   = ph_q;
    assign phase2_o  = ph2_q;
    assign down_o    = down_q;
    assign begun_o   = begun_q;

    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |-> (ph_q < period_i && ph2_q < period_i));  // R5
    AST_ELAPSED_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |-> (el_q <= period_i + 1'b1));  // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !step_i) |=> ($stable(el_q) && $stable(down_q) && $stable(ph_q)));  // R12

endmodule

// File: rtl/pit_out_decode.sv
// Output and readback decoder. It forms the output level and the readback
// count from the captured mode and the core state.
// Purely combinational; assumes core state is consistent with period_i.
module pit_out_decode
    import pit_pkg::*;
#(
    parameter int CW = 16,
    localparam int NW = CW + 1
) (
    input  pit_mode_e     mode_i,
    input  logic [NW-1:0] period_i,
    input  logic [NW-1:0] elapsed_i,
    input  logic [NW-1:0] phase_i,
    input  logic [NW-1:0] phase2_i,
    input  logic [CW-1:0] down_i,
    input  logic          begun_i,
    output logic          out_o,
    output logic [CW-1:0] count_o
);

    logic [NW:0] half;

    // First-half length of the square-wave period.
    always_comb begin
        half = ({1'b0, period_i} + 1'b1) >> 1;
    end

    // Mode-dependent output level and readback value.
    always_comb begin
        case (mode_i)
            MODE_RATE: begin
                out_o   = !((phase_i == '0) && begun_i);
                count_o = CW'(period_i - phase_i);
            end
            MODE_SQUARE: begin
                out_o   = ({1'b0, phase_i} < half);
                count_o = CW'(period_i - phase2_i);
            end
            MODE_SWSTB, MODE_HWSTB: begin
                out_o   = (elapsed_i == period_i);
                count_o = down_i;
            end
            default: begin
                out_o   = (elapsed_i >= period_i);
                count_o = down_i;
            end
        endcase
    end

endmodule

// File: rtl/pit_channel.sv
// Top of one programmable interval timer channel.
// Joins the configuration register, gate control, counting core and decoder.
// A load has priority over a gate restart, which has priority over a step.
module pit_channel
    import pit_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] reload_i,
    input  logic [2:0]    mode_i,
    input  logic          gate_i,
    input  logic          tick_i,
    output logic          out_o,
    output logic [CW-1:0] count_o
);

    localparam int NW = CW + 1;

    logic [NW-1:0] period_q, period_nx;
    pit_mode_e     mode_q;
    logic          run, restart, clear, step;
    logic [NW-1:0] elapsed, phase, phase2;
    logic [CW-1:0] down;
    logic          begun;

    pit_cfg_reg #(.CW(CW)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .reload_i   (reload_i),
        .mode_i     (mode_i),
        .period_q_o (period_q),
        .period_nx_o(period_nx),
        .mode_q_o   (mode_q)
    );

    pit_gate_ctl u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate_i   (gate_i),
        .tick_i   (tick_i),
        .mode_i   (mode_q),
        .run_o    (run),
        .restart_o(restart)
    );

    // Priority between load, restart and step.
    always_comb begin
        clear = load_i | restart;
        step  = run & ~clear;
    end

    pit_count_core #(.CW(CW)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear),
        .step_i   (step),
        .period_i (period_nx),
        .elapsed_o(elapsed),
        .phase_o  (phase),
        .phase2_o (phase2),
        .down_o   (down),
        .begun_o  (begun)
    );

    pit_out_decode #(.CW(CW)) u_dec (
        .mode_i   (mode_q),
        .period_i (period_q),
        .elapsed_i(elapsed),
        .phase_i  (phase),
        .phase2_i (phase2),
        .down_i   (down),
        .begun_i  (begun),
        .out_o    (out_o),
        .count_o  (count_o)
    );

    AST_TERM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_TERM && out_o && !load_i) |=> out_o);  // R3
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == MODE_SWSTB || mode_q == MODE_HWSTB) && out_o && step) |=> !out_o);  // R7
    AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == MODE_TERM || mode_q == MODE_SWSTB) && !gate_i && !load_i)
            |=> ($stable(count_o) && $stable(out_o)));  // R9
    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && reload_i != '0) |=> (count_o == $past(reload_i)));  // R10

endmodule

// File: tb/sim_pit_channel.sv
// Self-checking bench for pit_channel: directed corners plus seeded random traffic.
module sim_pit_channel;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [15:0] reload_i = '0;
    logic [2:0]  mode_i = '0;
    logic        gate_i = 1'b0;
    logic        tick_i = 1'b0;
    logic        out_o;
    logic [15:0] count_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    bit primed = 0;

    // Reference model state.
    longint m_n = 65536;
    int     m_md = 0;
    longint m_d = 0;
    bit     m_gq = 0;

    pit_channel u0 (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .reload_i(reload_i),
        .mode_i(mode_i), .gate_i(gate_i), .tick_i(tick_i),
        .out_o(out_o), .count_o(count_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int fold(input int raw);
        if (raw == 6) return 2;
        if (raw == 7) return 3;
        return raw;
    endfunction

    function automatic bit e_out(input int md, input longint n, input longint d);
        case (md)
            2: return !((d % n) == 0 && d != 0);
            3: return (d % n) < ((n + 1) / 2);
            4, 5: return d == n;
            default: return d >= n;
        endcase
    endfunction

    function automatic int e_cnt(input int md, input longint n, input longint d);
        longint v;
        case (md)
            2: v = n - (d % n);
            3: v = n - ((2 * d) % n);
            default: v = n - d;
        endcase
        return int'(v & 64'hFFFF);
    endfunction

    function automatic string mode_tag(input int md);
        case (md)
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4, 5: return "R7";
            default: return "R3";
        endcase
    endfunction

    task automatic compare(input string tag);
        bit eo;
        int ec;
        eo = e_out(m_md, m_n, m_d);
        ec = e_cnt(m_md, m_n, m_d);
        n_chk++;
        if (out_o !== eo) begin
            n_bad++;
            $display("FAIL %s/%s out_o actual %0d expected %0d (d=%0d)", tag, mode_tag(m_md), out_o, eo, m_d);
        end
        n_chk++;
        if (count_o !== 16'(ec)) begin
            n_bad++;
            $display("FAIL %s/%s count_o actual %0d expected %0d (d=%0d)", tag, mode_tag(m_md), count_o, ec, m_d);
        end
    endtask

    // One cycle: check state from the last edge, then drive and advance the model.
    task automatic cyc(input bit r, input bit ld, input logic [15:0] rv, input logic [2:0] md,
                       input bit g, input bit ce, input string tag);
        bit rise;
        @(negedge clk);
        if (primed) compare(tag);
        rst_n = r; load_i = ld; reload_i = rv; mode_i = md; gate_i = g; tick_i = ce;
        if (!r) begin
            m_n = 65536; m_md = 0; m_d = 0; m_gq = 0;
        end else begin
            rise = g && !m_gq;
            if (ld) begin
                m_n  = (rv == 0) ? 65536 : longint'(rv);
                m_md = fold(int'(md));
                m_d  = 0;
            end else if (rise && (m_md == 1 || m_md == 2 || m_md == 3 || m_md == 5)) begin
                m_d = 0;
            end else if (ce && ((m_md != 0 && m_md != 4) || g)) begin
                m_d++;
            end
            m_gq = g;
        end
        primed = 1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240607));

        // R1: reset state.
        repeat (3) cyc(0, 0, 16'd0, 3'd0, 0, 0, "R1");
        cyc(1, 0, 16'd0, 3'd0, 0, 0, "R1");
        cyc(1, 0, 16'd0, 3'd5, 0, 0, "R1");

        // R3 with R9: mode 0, pause with the gate low, re-raise without restart.
        cyc(1, 1, 16'd5, 3'd0, 1, 0, "R3");
        repeat (3) cyc(1, 0, 16'd0, 3'd0, 1, 1, "R3");
        repeat (3) cyc(1, 0, 16'd0, 3'd0, 0, 1, "R9");
        repeat (6) cyc(1, 0, 16'd0, 3'd0, 1, 1, "R9");

        // R4, R5, R6, R7 with gate restarts (R8), ticks every other cycle (R12).
        for (int md = 1; md <= 5; md++) begin
            cyc(1, 1, 16'd5, 3'(md), 1, 0, "R10");
            for (int k = 0; k < 14; k++) cyc(1, 0, 16'd0, 3'd0, 1, k[0], "R12");
            cyc(1, 0, 16'd0, 3'd0, 0, 1, "R8");
            for (int k = 0; k < 10; k++) cyc(1, 0, 16'd0, 3'd0, 1, 1, "R8");
        end

        // R11: aliased codes, odd and even periods.
        cyc(1, 1, 16'd4, 3'd6, 1, 1, "R11");
        repeat (10) cyc(1, 0, 16'd0, 3'd1, 1, 1, "R11");
        cyc(1, 1, 16'd7, 3'd7, 1, 1, "R11");
        repeat (16) cyc(1, 0, 16'd0, 3'd2, 1, 1, "R11");

        // R6 with R5: period of one, and square wave from a zero reload.
        cyc(1, 1, 16'd1, 3'd2, 1, 1, "R5");
        repeat (4) cyc(1, 0, 16'd0, 3'd0, 1, 1, "R5");
        cyc(1, 1, 16'd0, 3'd3, 1, 1, "R6");
        repeat (6) cyc(1, 0, 16'd0, 3'd0, 1, 1, "R6");

        // R10: load wins over a simultaneous gate rise and tick.
        cyc(1, 0, 16'd0, 3'd0, 0, 0, "R10");
        cyc(1, 1, 16'd3, 3'd1, 1, 1, "R10");
        repeat (5) cyc(1, 0, 16'd0, 3'd4, 1, 1, "R10");

        // R2: zero reload in mode 0 runs the full 65536 steps.
        cyc(1, 1, 16'd0, 3'd0, 1, 1, "R2");
        repeat (65540) cyc(1, 0, 16'd0, 3'd0, 1, 1, "R2");

        // Random traffic.
        for (int i = 0; i < 20000; i++) begin
            bit ld, g, ce;
            logic [15:0] rv;
            logic [2:0] md;
            ld = ($urandom % 40) == 0;
            rv = (($urandom % 16) == 0) ? 16'd0 : 16'($urandom % 10);
            md = 3'($urandom % 8);
            g  = (($urandom % 8) == 0) ? ~gate_i : gate_i;
            ce = ($urandom % 5) < 3;
            cyc(1, ld, rv, md, g, ce, "R10");
        end
        cyc(1, 0, 16'd0, 3'd0, gate_i, 0, "R12");

        finish_run();
    end

endmodule